// File: doc/BRIEF.md
# Two-Rank Channel Code Bank

This block keeps the digital codes for four output channels of a converter. It has two ranks of registers. A staging rank of four registers takes a code from an upstream serial receiver. A live rank of four registers drives the converters. Codes enter the staging rank while a level-sensitive, active-low load is held. The code goes to the addressed channel, or to every channel when the broadcast flag is set. A rising edge on the update strobe then copies all four staged codes into the live rank in one clock. This lets several channels change at the same instant.

A clear strobe forces both ranks to one of two values on its rising edge. A separate select level picks the value: mid-scale or zero. Everything runs on one system clock. The update and clear strobes must already be synchronised to that clock. There is no streaming data path: the code input is a parallel word sampled on every clock while load is low, so the block has no valid/ready handshake.

Top module: `dac_bank`

## Requirements
- R1: While reset (`rst_ni` low) is held and right after it is released, all four live codes read 8000h. Channel n sits at `dac_code_o[16n+15:16n]`.
- R2: On every clock where `load_ni` is 0, `bcast_i` is 0 and there is no clear edge, the staging register addressed by `addr_i` takes `code_i` as straight binary. Address 0, 1, 2 and 3 pick channel 0, 1, 2 and 3.
- R3: On every clock where `load_ni` is 0 and `bcast_i` is 1, all four staging registers take `code_i`, whatever `addr_i` holds.
- R4: In the clock where `upd_i` is 1 and was 0 in the clock before, all four live registers take the staging contents as they stood before that edge, all at once.
- R5: A steady `upd_i` level, high or low, never changes the live rank. A level that is already high when reset is released is not an edge.
- R6: While `load_ni` is 1, the staging rank holds, whatever `addr_i`, `bcast_i` and `code_i` do.
- R7: In the clock where `clr_i` rises, both ranks become 8000h if `clr_mid_i` is 1, or 0000h if it is 0. Holding `clr_i` high does not clear again.
- R8: A clear edge wins over a load or an update edge in the same clock. Both ranks end up at the clear value.
- R9: If the address changes while `load_ni` stays low, every channel the address passes through picks up the code present during its clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| addr_i | input | 2 | Channel address of the staged code |
| bcast_i | input | 1 | Write the code to every staging register |
| code_i | input | 16 | Code word from the serial receiver |
| load_ni | input | 1 | Active-low level-sensitive staging load |
| upd_i | input | 1 | Synchronised update strobe, acts on its rising edge |
| clr_i | input | 1 | Synchronised clear strobe, acts on its rising edge |
| clr_mid_i | input | 1 | Clear value select: 1 gives mid-scale, 0 gives zero |
| dac_code_o | output | 64 | Four live codes, channel n at bits 16n+15:16n |

## Verification
The bench goes after edge detection. It holds the update strobe high for many clocks and checks that the live rank stays put. A design that loaded on the level would pick up codes staged in the meantime. It also holds load low while the address walks across channels, and checks that every channel it passes is overwritten. A design that latched only the final address would leave those channels alone. Clears are fired together with an update edge and an open load, and are held high over a later load. A design with the wrong priority, or one that kept clearing on the level, would show codes other than the clear value.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_ZERO = 2'd1,
    CLR_MID  = 2'd2
  } clr_cmd_e;
endpackage

// File: rtl/dbk_edge.sv
module dbk_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  // Starts high so that a level already high at reset release is no edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/dbk_in_rank.sv
module dbk_in_rank
  import dac_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  clr_cmd_e          clr_cmd_i,
  input  logic              load_ni,
  input  logic              bcast_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [CW-1:0]     code_i,
  output logic [NCH*CW-1:0] rank_o
);
  localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic          hit;
    logic [CW-1:0] val_q;

    assign hit = !load_ni && (bcast_i || (addr_i == AW'(ch)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    val_q <= MID;
      else if (clr_cmd_i == CLR_MID)  val_q <= MID;
      else if (clr_cmd_i == CLR_ZERO) val_q <= '0;
      else if (hit)                   val_q <= code_i;
    end

    assign rank_o[ch*CW +: CW] = val_q;
  end
endmodule

// File: rtl/dbk_out_rank.sv
module dbk_out_rank
  import dac_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  clr_cmd_e          clr_cmd_i,
  input  logic              upd_i,
  input  logic [NCH*CW-1:0] rank_i,
  output logic [NCH*CW-1:0] rank_o
);
  localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rank_o <= {NCH{MID}};
    else if (clr_cmd_i == CLR_MID)  rank_o <= {NCH{MID}};
    else if (clr_cmd_i == CLR_ZERO) rank_o <= '0;
    else if (upd_i)                 rank_o <= rank_i;
  end
endmodule

// File: rtl/dac_bank.sv
module dac_bank
  import dac_bank_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              bcast_i,
  input  logic [CW-1:0]     code_i,
  input  logic              load_ni,
  input  logic              upd_i,
  input  logic              clr_i,
  input  logic              clr_mid_i,
  output logic [NCH*CW-1:0] dac_code_o
);
  logic              upd_rise;
  logic              clr_rise;
  clr_cmd_e          clr_cmd;
  logic [NCH*CW-1:0] in_rank_w;

  dbk_edge u_upd_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (upd_i), .rise_o (upd_rise)
  );

  dbk_edge u_clr_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .lvl_i (clr_i), .rise_o (clr_rise)
  );

  always_comb begin
    if (!clr_rise)      clr_cmd = CLR_NONE;
    else if (clr_mid_i) clr_cmd = CLR_MID;
    else                clr_cmd = CLR_ZERO;
  end

  dbk_in_rank #(.NCH(NCH), .CW(CW)) u_in (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_cmd_i (clr_cmd),
    .load_ni   (load_ni),
    .bcast_i   (bcast_i),
    .addr_i    (addr_i),
    .code_i    (code_i),
    .rank_o    (in_rank_w)
  );

  dbk_out_rank #(.NCH(NCH), .CW(CW)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_cmd_i (clr_cmd),
    .upd_i     (upd_rise),
    .rank_i    (in_rank_w),
    .rank_o    (dac_code_o)
  );
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic              bcast_i,
  input logic [CW-1:0]     code_i,
  input logic              load_ni,
  input logic              upd_i,
  input logic              clr_i,
  input logic              clr_mid_i,
  input logic [NCH*CW-1:0] dac_code_o,
  input logic [NCH*CW-1:0] in_rank
);
  localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

  // R1
  reset_mid_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> dac_code_o == {NCH{MID}});

  // R5
  live_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !(upd_i && !$past(upd_i)) && !(clr_i && !$past(clr_i)))
    |=> $stable(dac_code_o));

  // R4
  live_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && upd_i && !$past(upd_i) && !(clr_i && !$past(clr_i)))
    |=> dac_code_o == $past(in_rank));

  // R7
  clr_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && clr_i && !$past(clr_i))
    |=> (dac_code_o == {NCH{$past(clr_mid_i) ? MID : CW'(0)}}) &&
        (in_rank == {NCH{$past(clr_mid_i) ? MID : CW'(0)}}));

  // R8
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && clr_i && !$past(clr_i) && upd_i && !$past(upd_i) && !load_ni)
    |=> dac_code_o == {NCH{$past(clr_mid_i) ? MID : CW'(0)}});

  // R3
  bcast_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !load_ni && bcast_i && !(clr_i && !$past(clr_i)))
    |=> in_rank == {NCH{$past(code_i)}});

  // R2
  addr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !load_ni && !bcast_i && !(clr_i && !$past(clr_i)))
    |=> in_rank[$past(addr_i)*CW +: CW] == $past(code_i));
endmodule

bind dac_bank dac_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .bcast_i    (bcast_i),
  .code_i     (code_i),
  .load_ni    (load_ni),
  .upd_i      (upd_i),
  .clr_i      (clr_i),
  .clr_mid_i  (clr_mid_i),
  .dac_code_o (dac_code_o),
  .in_rank    (in_rank_w)
);

// File: tb/sim_dac_bank.sv
module sim_dac_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = '0;
  logic        bcast_i = 1'b0;
  logic [15:0] code_i = '0;
  logic        load_ni = 1'b1;
  logic        upd_i = 1'b0;
  logic        clr_i = 1'b0;
  logic        clr_mid_i = 1'b0;
  logic [63:0] dac_code_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  int ref_in [4];
  int ref_out[4];
  bit prev_upd, prev_clr;

  always #4 clk = ~clk;

  dac_bank u0 (
    .clk_i (clk), .rst_ni (rst_ni), .addr_i (addr_i), .bcast_i (bcast_i),
    .code_i (code_i), .load_ni (load_ni), .upd_i (upd_i), .clr_i (clr_i),
    .clr_mid_i (clr_mid_i), .dac_code_o (dac_code_o)
  );

  // Behavioural reference of both ranks, built from the requirements.
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (ref_in[i])  ref_in[i]  = 'h8000;
      foreach (ref_out[i]) ref_out[i] = 'h8000;
      prev_upd = 1'b1;
      prev_clr = 1'b1;
    end else begin
      if (clr_i && !prev_clr) begin
        foreach (ref_in[i]) begin
          ref_in[i]  = clr_mid_i ? 'h8000 : 0;
          ref_out[i] = clr_mid_i ? 'h8000 : 0;
        end
      end else begin
        if (upd_i && !prev_upd) foreach (ref_out[i]) ref_out[i] = ref_in[i];
        if (!load_ni) begin
          if (bcast_i) foreach (ref_in[i]) ref_in[i] = int'(code_i);
          else ref_in[addr_i] = int'(code_i);
        end
      end
      prev_upd = upd_i;
      prev_clr = clr_i;
    end
  end

  // Compare against the model on every clock.
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      for (int i = 0; i < 4; i++) begin
        checks++;
        if (int'(dac_code_o[i*16 +: 16]) != ref_out[i]) begin
          errors++;
          $display("FAIL %s model ch%0d actual %h expected %h", cur_req, i,
                   dac_code_o[i*16 +: 16], ref_out[i][15:0]);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_all(string req, logic [15:0] e0, logic [15:0] e1,
                         logic [15:0] e2, logic [15:0] e3);
    logic [63:0] exp_v;
    exp_v = {e3, e2, e1, e0};
    checks++;
    if (dac_code_o !== exp_v) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, dac_code_o, exp_v);
    end
  endtask

  task automatic stage(logic [1:0] a, logic [15:0] c);
    addr_i = a; code_i = c; load_ni = 1'b0; bcast_i = 1'b0;
    tick(1);
    load_ni = 1'b1;
  endtask

  task automatic pulse_upd();
    upd_i = 1'b1; tick(1); upd_i = 1'b0; tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(4);
    cur_req = "R1";
    chk_all("R1 during reset", 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    rst_ni = 1'b1;
    tick(2);
    chk_all("R1 after release", 16'h8000, 16'h8000, 16'h8000, 16'h8000);

    cur_req = "R2";
    stage(2'd0, 16'h1111); stage(2'd1, 16'h2222);
    stage(2'd2, 16'h3333); stage(2'd3, 16'hFFFF);
    tick(1);
    chk_all("R2 staged not live", 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    cur_req = "R4";
    pulse_upd();
    chk_all("R2/R4 per-address load", 16'h1111, 16'h2222, 16'h3333, 16'hFFFF);

    cur_req = "R6";
    load_ni = 1'b1;
    for (int k = 0; k < 4; k++) begin
      addr_i = 2'(k); bcast_i = k[0]; code_i = 16'hDEAD + 16'(k); tick(1);
    end
    bcast_i = 1'b0;
    pulse_upd();
    chk_all("R6 load high holds", 16'h1111, 16'h2222, 16'h3333, 16'hFFFF);

    cur_req = "R3";
    addr_i = 2'd2; bcast_i = 1'b1; code_i = 16'hABCD; load_ni = 1'b0; tick(1);
    load_ni = 1'b1; bcast_i = 1'b0;
    pulse_upd();
    chk_all("R3 broadcast", 16'hABCD, 16'hABCD, 16'hABCD, 16'hABCD);

    cur_req = "R5";
    upd_i = 1'b1; tick(1);
    chk_all("R4 edge copy", 16'hABCD, 16'hABCD, 16'hABCD, 16'hABCD);
    stage(2'd1, 16'h0001);
    tick(5);
    chk_all("R5 steady high no load", 16'hABCD, 16'hABCD, 16'hABCD, 16'hABCD);
    upd_i = 1'b0; tick(5);
    chk_all("R5 steady low no load", 16'hABCD, 16'hABCD, 16'hABCD, 16'hABCD);
    pulse_upd();
    chk_all("R5 fresh edge loads", 16'hABCD, 16'h0001, 16'hABCD, 16'hABCD);

    cur_req = "R9";
    load_ni = 1'b0; bcast_i = 1'b0;
    addr_i = 2'd0; code_i = 16'h0A0A; tick(1);
    addr_i = 2'd2; code_i = 16'h0B0B; tick(1);
    addr_i = 2'd3; code_i = 16'h0C0C; tick(1);
    load_ni = 1'b1;
    pulse_upd();
    chk_all("R9 rippling address corrupts", 16'h0A0A, 16'h0001, 16'h0B0B, 16'h0C0C);

    cur_req = "R7";
    clr_mid_i = 1'b0; clr_i = 1'b1; tick(1);
    chk_all("R7 clear to zero", 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    stage(2'd1, 16'h7777);
    tick(2);
    pulse_upd();
    chk_all("R7 held clear no repeat", 16'h0000, 16'h7777, 16'h0000, 16'h0000);
    clr_i = 1'b0; tick(1);
    clr_mid_i = 1'b1; clr_i = 1'b1; tick(1); clr_i = 1'b0;
    chk_all("R7 clear to mid", 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    pulse_upd();
    chk_all("R7 staging also cleared", 16'h8000, 16'h8000, 16'h8000, 16'h8000);

    cur_req = "R8";
    stage(2'd3, 16'h4321);
    pulse_upd();
    chk_all("R8 setup", 16'h8000, 16'h8000, 16'h8000, 16'h4321);
    clr_mid_i = 1'b0; clr_i = 1'b1; upd_i = 1'b1; load_ni = 1'b0; bcast_i = 1'b1;
    code_i = 16'h5555; tick(1);
    load_ni = 1'b1; bcast_i = 1'b0; clr_i = 1'b0; upd_i = 1'b0;
    chk_all("R8 clear beats update", 16'h0000, 16'h0000, 16'h0000, 16'h0000);
    tick(1);
    pulse_upd();
    chk_all("R8 clear beats load", 16'h0000, 16'h0000, 16'h0000, 16'h0000);

    tick(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule